// File: doc/BRIEF.md
# SPI Register Access Port

This block is an SPI slave (clock idle low, data sampled on the rising SCLK edge, changed on the falling edge) that lets an external host read and write a 128-location byte-wide control/status register map. The SPI pins are brought into the system clock domain through two-flop synchronisers. All framing and shifting runs on edges detected in that domain. The system clock must be at least four times the SCLK rate.

A transfer is framed by chip select being held low. The host first sends a command byte. Its most significant bit asks for a read-only transfer, and its low seven bits give the register address where the transfer begins. Every byte that follows is full duplex. While the host shifts in a new value on MOSI, the block shifts out on MISO what the current register held when the byte began. At the end of the byte the incoming value is written to that register, unless the transfer is read-only. The address then moves on by one and wraps at the top of the map. On the register side the block drives an address, write data, a write strobe and a read strobe. It takes read data back combinationally in the same cycle as the read strobe.

Top module: `spi_regport`

## Requirements
- R1: While reset is held and immediately after it, reg_we, reg_re and miso are all 0.
- R2: Bit 7 of the first byte after chip select falls is the read-only flag, and bits 6:0 are the address that the first data byte accesses.
- R3: In a transfer whose read-only flag is 0, each completed data byte writes the byte received on MOSI (MSB first) to the current address with exactly one single-cycle reg_we pulse.
- R4: In a transfer whose read-only flag is 1, reg_we never asserts and no register changes.
- R5: During each data byte, miso carries MSB first the content of the current address as it was before that byte's write.
- R6: miso is 0 throughout the command byte and whenever chip select is high.
- R7: After each data byte the address advances by one, wrapping from 127 to 0. The read strobe for the next address follows the write strobe by one cycle.
- R8: Raising chip select part way through a byte discards that partial byte without a write. The next transfer again starts with a command byte.
- R9: reg_re is a single-cycle pulse, issued once after the command byte and once after every data byte, and it never coincides with reg_we.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the host, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, 0 when not selected |
| reg_addr | output | 7 | Register map address |
| reg_wdata | output | 8 | Write data for the register map |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid in the same cycle as reg_re |

## Verification
The assertions assume the following about the inputs. SCLK is slow enough that a falling edge is detected no sooner than two system cycles after the rising edge before it. MOSI is stable around each rising edge. Chip select stays low for a whole command byte before a new transfer can begin, so a write or read pipeline left over from one frame drains before the next frame's first write. The stimulus holds each SCLK phase for six system clocks and changes MOSI only while SCLK is low. It keeps chip select low for several cycles before the first and after the last edge. All inputs are driven on the falling system clock edge.

// File: rtl/spi_regport_pkg.sv
// Shared constants and types for the SPI register access port.
package spi_regport_pkg;

    // Width of a register-map address (128 locations).
    localparam int unsigned REG_ADDR_W = 7;
    // Width of one register and of one SPI byte.
    localparam int unsigned REG_DATA_W = 8;

    // Transfer phase: waiting for the command byte, or streaming data bytes.
    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } xfer_phase_e;

endpackage

// File: rtl/spi_pin_sync.sv
// Brings SCLK, CS_n and MOSI into the system clock domain through a chain of
// STAGES flops per pin, then detects SCLK edges on the synchronised level.
// Assumes: the system clock runs at least four times faster than SCLK, and
// MOSI is stable around each rising SCLK edge. Edge strobes are suppressed
// while chip select is inactive.
module spi_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_pin,
    input  logic cs_n_pin,
    input  logic mosi_pin,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic mosi_bit
);

    localparam int unsigned NPINS = 3;
    localparam int unsigned LAST  = STAGES - 1;
    // Bit order inside the bundle: {sclk, cs_n, mosi}; chip select idles high.
    localparam logic [NPINS-1:0] IDLE = 3'b010;

    logic [NPINS-1:0] pins_raw;
    logic [NPINS-1:0] sync_q [STAGES];
    logic             sclk_last_q;
    logic             sclk_now;

    assign pins_raw = {sclk_pin, cs_n_pin, mosi_pin};

    // Purpose: shift every pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                sync_q[s] <= IDLE;
            end
        end else begin
            sync_q[0] <= pins_raw;
            for (int s = 1; s < STAGES; s++) begin
                sync_q[s] <= sync_q[s-1];
            end
        end
    end

    // Purpose: remember the previous synchronised SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_last_q <= 1'b0;
        end else begin
            sclk_last_q <= sclk_now;
        end
    end

    assign sclk_now  = sync_q[LAST][2];
    assign cs_active = !sync_q[LAST][1];
    assign mosi_bit  = sync_q[LAST][0];
    assign sclk_rise = cs_active &&  sclk_now && !sclk_last_q;
    assign sclk_fall = cs_active && !sclk_now &&  sclk_last_q;

endmodule

// File: rtl/spi_shift_engine.sv
// Bit-level engine of the SPI slave. It assembles MOSI bits into bytes on
// rising SCLK edges and shifts MISO out MSB first on falling edges.
// The first falling edge after a completed byte loads the next outgoing byte
// from tx_load_data; later falling edges shift. Clearing chip select discards
// any partial byte and zeroes the transmit register.
// Assumes: edge strobes come from spi_pin_sync and are gated by chip select.
module spi_shift_engine #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_active,
    input  logic              mosi_bit,
    input  logic [DATA_W-1:0] tx_load_data,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              miso
);

    localparam int unsigned CNT_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DATA_W-2:0] rx_sh_q;
    logic [DATA_W-1:0] tx_sh_q;

    // Purpose: count received bits and collect MOSI on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
        end else if (!cs_active) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
        end else if (sclk_rise) begin
            rx_sh_q   <= rx_byte[DATA_W-2:0];
            bit_cnt_q <= (bit_cnt_q == LAST_BIT) ? '0 : bit_cnt_q + 1'b1;
        end
    end

    // Purpose: load or shift the outgoing byte on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
        end else if (!cs_active) begin
            tx_sh_q <= '0;
        end else if (sclk_fall) begin
            if (bit_cnt_q == '0) begin
                tx_sh_q <= tx_load_data;
            end else begin
                tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign rx_byte   = {rx_sh_q, mosi_bit};
    assign byte_done = sclk_rise && (bit_cnt_q == LAST_BIT);
    assign miso      = cs_active && tx_sh_q[DATA_W-1];

endmodule

// File: rtl/spi_txn_ctrl.sv
// Transfer-level control. The first completed byte of a frame is decoded as
// a command: the top bit is the read-only flag, the rest is the start address.
// Each later byte is written back (unless read-only), the address advances,
// and the next location is read one cycle later. Its data is held for the
// engine to load at the next byte boundary.
// Assumes: reg_rdata is valid combinationally in the cycle reg_re is high.
// The engine's first load comes at least two cycles after byte_done.
module spi_txn_ctrl
    import spi_regport_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    output logic [DATA_W-1:0] tx_load_data,
    output logic              in_cmd,
    output logic              ro_flag
);

    localparam int unsigned RO_BIT = DATA_W - 1;

    xfer_phase_e       phase_q;
    logic              ro_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic              step_q;
    logic              step_inc_q;
    logic              re_q;
    logic [DATA_W-1:0] prefetch_q;

    // Purpose: track the phase of the frame and latch the command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CMD;
            ro_q    <= 1'b0;
        end else if (!cs_active) begin
            phase_q <= PH_CMD;
        end else if (byte_done && phase_q == PH_CMD) begin
            phase_q <= PH_DATA;
            ro_q    <= rx_byte[RO_BIT];
        end
    end

    // Purpose: issue the write strobe and schedule the address step for each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q       <= 1'b0;
            wdata_q    <= '0;
            step_q     <= 1'b0;
            step_inc_q <= 1'b0;
        end else begin
            we_q   <= 1'b0;
            step_q <= 1'b0;
            if (cs_active && byte_done) begin
                step_q <= 1'b1;
                if (phase_q == PH_CMD) begin
                    step_inc_q <= 1'b0;
                end else begin
                    step_inc_q <= 1'b1;
                    we_q       <= !ro_q;
                    wdata_q    <= rx_byte;
                end
            end
        end
    end

    // Purpose: hold the register address, load it from a command, advance after data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (cs_active && byte_done && phase_q == PH_CMD) begin
            addr_q <= rx_byte[ADDR_W-1:0];
        end else if (step_q && step_inc_q) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    // Purpose: pulse the read strobe one cycle after each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            re_q <= 1'b0;
        end else begin
            re_q <= step_q;
        end
    end

    // Purpose: keep the fetched register content for the next outgoing byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prefetch_q <= '0;
        end else if (re_q) begin
            prefetch_q <= reg_rdata;
        end
    end

    assign tx_load_data = re_q ? reg_rdata : prefetch_q;
    assign reg_addr     = addr_q;
    assign reg_wdata    = wdata_q;
    assign reg_we       = we_q;
    assign reg_re       = re_q;
    assign in_cmd       = (phase_q == PH_CMD);
    assign ro_flag      = ro_q;

endmodule

// File: rtl/spi_regport.sv
// Top of the SPI register access port: pin synchroniser, bit engine and
// transfer control. Each frame is one command byte (read-only flag and start
// address) followed by full-duplex data bytes on consecutive registers.
// Assumes: the system clock runs at four or more times SCLK. The register
// map returns data combinationally in the same cycle as reg_re.
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int unsigned ADDR_W      = REG_ADDR_W,
    parameter int unsigned DATA_W      = REG_DATA_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);

    logic              sclk_rise;
    logic              sclk_fall;
    logic              cs_active;
    logic              mosi_bit;
    logic              byte_done;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] tx_load_data;
    logic              in_cmd;
    logic              ro_flag;

    spi_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_pin  (sclk),
        .cs_n_pin  (cs_n),
        .mosi_pin  (mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_active (cs_active),
        .mosi_bit  (mosi_bit)
    );

    spi_shift_engine #(
        .DATA_W (DATA_W)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_rise    (sclk_rise),
        .sclk_fall    (sclk_fall),
        .cs_active    (cs_active),
        .mosi_bit     (mosi_bit),
        .tx_load_data (tx_load_data),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .miso         (miso)
    );

    spi_txn_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_active    (cs_active),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .reg_rdata    (reg_rdata),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_we       (reg_we),
        .reg_re       (reg_re),
        .tx_load_data (tx_load_data),
        .in_cmd       (in_cmd),
        .ro_flag      (ro_flag)
    );

endmodule

// File: rtl/spi_regport_chk.sv
// Protocol checker for spi_regport, bound to the top module.
// Assumes the input timing given in the brief.
module spi_regport_chk #(
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              reg_re,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              miso,
    input logic              in_cmd,
    input logic              ro_flag
);

    // R3: the write strobe lasts one cycle.
    assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R4: no write happens while the frame is read-only.
    assert_ro_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !ro_flag);

    // R6: nothing is driven on miso while the command byte is awaited.
    assert_cmd_miso_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_cmd |-> !miso);

    // R7: a write is followed by a read of the next address, modulo 128.
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_re && (reg_addr - $past(reg_addr)) == ADDR_W'(1)));

    // R9: read strobe is a single-cycle pulse.
    assert_re_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    // R9: read and write strobes never overlap.
    assert_we_re_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

endmodule

bind spi_regport spi_regport_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .miso     (miso),
    .in_cmd   (in_cmd),
    .ro_flag  (ro_flag)
);

// File: tb/tb_spi_regport.sv
// Self-checking bench: a register array behind the port, an SPI master task,
// a vector table of frames, then directed reset, abort and idle checks.
module tb_spi_regport;

    localparam int HALF  = 6;
    localparam int NVEC  = 6;
    localparam int NREGS = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic       reg_re;
    logic [7:0] reg_rdata;

    logic [7:0] regs [NREGS];
    logic [7:0] mdl  [NREGS];
    logic [7:0] txb  [8];
    logic [7:0] rxb  [8];
    logic [7:0] expb [8];
    logic [7:0] cmd_seen;

    int checks = 0;
    int errors = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_regport dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .miso      (miso),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata)
    );

    assign reg_rdata = regs[reg_addr];

    // Register file model and strobe counters.
    always @(posedge clk) begin
        if (reg_we) regs[reg_addr] <= reg_wdata;
        if (reg_we) we_cnt <= we_cnt + 1;
        if (reg_re) re_cnt <= re_cnt + 1;
    end

    // Vector table: command byte, data byte count, data bytes.
    localparam logic [7:0] V_CMD [NVEC] = '{8'h10, 8'h90, 8'h7E, 8'hFE, 8'h20, 8'h00};
    localparam int         V_N   [NVEC] = '{4, 4, 4, 4, 1, 3};
    localparam logic [7:0] V_DAT [NVEC][4] = '{
        '{8'hAA, 8'h55, 8'h0F, 8'hF0},
        '{8'h01, 8'h02, 8'h03, 8'h04},
        '{8'hC3, 8'h3C, 8'h81, 8'h7E},
        '{8'hFF, 8'hEE, 8'hDD, 8'hCC},
        '{8'h5A, 8'h00, 8'h00, 8'h00},
        '{8'h11, 8'h22, 8'h33, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] d, input int nbits, output logic [7:0] got);
        got = 8'h00;
        for (int b = 0; b < nbits; b++) begin
            mosi = d[7-b];
            repeat (HALF) @(negedge clk);
            got[7-b] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    // One frame: command, n data bytes from txb; the last byte is cut short if cut > 0.
    task automatic xfer(input logic [7:0] cmd, input int n, input int cut);
        logic [7:0] g;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        send_byte(cmd, 8, g);
        cmd_seen = g;
        for (int i = 0; i < n; i++) begin
            send_byte(txb[i], (i == n - 1 && cut > 0) ? cut : 8, g);
            rxb[i] = g;
        end
        repeat (6) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic cmp_regs(input string req);
        int bad = -1;
        for (int k = 0; k < NREGS; k++) begin
            if (regs[k] !== mdl[k] && bad < 0) bad = k;
        end
        chk(bad < 0, req, (bad < 0) ? 0 : int'(regs[bad]), (bad < 0) ? 0 : int'(mdl[bad]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NREGS; k++) begin
            regs[k] = 8'((k * 29 + 3) & 8'hFF);
            mdl[k]  = 8'((k * 29 + 3) & 8'hFF);
        end
        // R1: outputs quiet during reset.
        repeat (4) @(negedge clk);
        chk(reg_we == 1'b0, "R1 we in reset", int'(reg_we), 0);
        chk(reg_re == 1'b0, "R1 re in reset", int'(reg_re), 0);
        chk(miso == 1'b0, "R1 miso in reset", int'(miso), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(reg_we == 1'b0 && reg_re == 1'b0 && miso == 1'b0, "R1 after reset",
            int'({reg_we, reg_re, miso}), 0);

        // Vector table walk.
        for (int v = 0; v < NVEC; v++) begin
            automatic logic [6:0] a = V_CMD[v][6:0];
            automatic bit ro = V_CMD[v][7];
            automatic int we0 = we_cnt;
            automatic int re0 = re_cnt;
            for (int i = 0; i < V_N[v]; i++) begin
                txb[i]  = V_DAT[v][i];
                expb[i] = mdl[a];
                if (!ro) mdl[a] = V_DAT[v][i];
                a = a + 7'd1;
            end
            xfer(V_CMD[v], V_N[v], 0);
            chk(cmd_seen == 8'h00, "R6 miso during command", int'(cmd_seen), 0);
            chk(rxb[0] == expb[0], "R2 first byte at commanded address",
                int'(rxb[0]), int'(expb[0]));
            for (int i = 1; i < V_N[v]; i++) begin
                chk(rxb[i] == expb[i], "R5 miso read data", int'(rxb[i]), int'(expb[i]));
            end
            if (ro) begin
                chk(we_cnt == we0, "R4 no writes when read-only", we_cnt - we0, 0);
                cmp_regs("R4 map unchanged");
            end else begin
                chk(we_cnt - we0 == V_N[v], "R3 one write per byte", we_cnt - we0, V_N[v]);
                cmp_regs("R3 map written (R7 wrap)");
            end
            chk(re_cnt - re0 == V_N[v] + 1, "R9 read strobe count", re_cnt - re0, V_N[v] + 1);
        end

        // R6: miso low while deselected.
        chk(miso == 1'b0, "R6 miso with cs high", int'(miso), 0);

        // R8: abort after three bits of the second data byte.
        begin
            automatic int we0 = we_cnt;
            txb[0] = 8'h11;
            txb[1] = 8'h22;
            mdl[7'h40] = 8'h11;
            xfer(8'h40, 2, 3);
            chk(we_cnt - we0 == 1, "R8 partial byte not written", we_cnt - we0, 1);
            chk(regs[7'h41] == mdl[7'h41], "R8 register after abort",
                int'(regs[7'h41]), int'(mdl[7'h41]));
            txb[0] = 8'h99;
            xfer(8'hC1, 1, 0);
            chk(rxb[0] == mdl[7'h41], "R8 new frame decodes command",
                int'(rxb[0]), int'(mdl[7'h41]));
            chk(cmd_seen == 8'h00, "R6 miso during command after abort", int'(cmd_seen), 0);
            cmp_regs("R8 map after abort");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule